// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier Controller

This block multiplies two unsigned operands by repeated conditional addition and shifting. A five-state control machine runs an accumulator datapath. A one-cycle pulse on `start` makes the machine enter its load state, where the datapath captures both operands and clears the accumulator. The machine then loops. In a test state it looks at the low bit of the shifting multiplier. When that bit is one it takes an extra add step. Every iteration ends with a shift step. After the last shift it returns to idle and raises `done`.

The command strobes `load_cmd`, `add_cmd` and `shift_cmd` are brought out, together with `done`, so a neighbouring block can follow the schedule. Operand width is a parameter. The product is twice that wide. The state register holds the idle encoding from power-up, so the block works even if reset is never applied. Any encoding that names no state falls back to idle on the next edge.

States: IDLE, LOAD (operand capture), TEST, ADD, SHIFT. Transitions:
- IDLE→LOAD on `start`, otherwise IDLE→IDLE.
- LOAD→TEST.
- TEST→ADD when the multiplier low bit is 1.
- TEST→SHIFT when the multiplier low bit is 0.
- ADD→SHIFT.
- SHIFT→IDLE after the W-th shift, otherwise SHIFT→TEST.
- Any unencoded value→IDLE.

Top module: `shiftadd_mul`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is IDLE: `done` reads 1 and all three command strobes read 0.
- R2: In IDLE with `start` low, the block stays idle, with `done` held at 1 and no command strobe raised.
- R3: `start` high in IDLE leads to exactly one cycle of `load_cmd` on the following cycle, and the TEST cycle after it raises no strobe.
- R4: From TEST, a multiplier low bit of 1 gives one `add_cmd` cycle followed by a `shift_cmd` cycle. A low bit of 0 gives `shift_cmd` directly. Over a run, the number of add cycles equals the number of one bits in the multiplier.
- R5: Each run issues exactly W shift cycles and then returns to IDLE. The busy time (cycles with `done` low) is 1 + 2·W + popcount(multiplier).
- R6: At most one of `load_cmd`, `add_cmd`, `shift_cmd`, `done` is high in any cycle.
- R7: When `done` returns high, `product` equals the unsigned product of the two operands sampled at the load step, with 2·W bits.
- R8: Without any reset, the block reads as idle (`done` = 1, no strobes) from the first clock on.
- R9: `start` pulses while a run is in progress are ignored. The run still issues a single `load_cmd`, gives the correct product, and stays idle afterwards.
- R10: Reset raised in the middle of a run returns the block to IDLE on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication (sampled in IDLE) |
| multiplicand | input | W | Unsigned multiplicand |
| multiplier | input | W | Unsigned multiplier |
| load_cmd | output | 1 | High in the LOAD state |
| add_cmd | output | 1 | High in the ADD state |
| shift_cmd | output | 1 | High in the SHIFT state |
| done | output | 1 | High in the IDLE state |
| product | output | 2·W | Accumulated product |

## Verification
The bench builds the block with its default width W = 8. This makes every operand pair tractable in a single run of 17 to 25 busy cycles, so extreme cases can be checked with exact cycle counts. Those cases are all-zero and all-ones operands, and alternating bit patterns that exercise both TEST branches. With W = 8, the iteration counter's last value (7) sits one below a power of two, so an off-by-one end condition shows up directly as a ninth shift or a wrong busy count.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_TEST  = 3'd2,
        ST_ADD   = 3'd3,
        ST_SHIFT = 3'd4
    } mul_state_e;
endpackage

// File: rtl/shiftadd_iter_cnt.sv
module shiftadd_iter_cnt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(W) + 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(W - 1);

    logic [CW-1:0] cnt_q = '0;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // true during the shift that completes the final iteration
    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/shiftadd_fsm.sv
module shiftadd_fsm
    import shiftadd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic lsb,
    input  logic last_shift,
    output logic load_o,
    output logic add_o,
    output logic shift_o,
    output logic idle_o
);
    mul_state_e state_q = ST_IDLE;
    mul_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_LOAD : ST_IDLE;
            ST_LOAD:  state_d = ST_TEST;
            ST_TEST:  state_d = lsb ? ST_ADD : ST_SHIFT;
            ST_ADD:   state_d = ST_SHIFT;
            ST_SHIFT: state_d = last_shift ? ST_IDLE : ST_TEST;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        add_o   = 1'b0;
        shift_o = 1'b0;
        idle_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle_o  = 1'b1;
            ST_LOAD:  load_o  = 1'b1;
            ST_ADD:   add_o   = 1'b1;
            ST_SHIFT: shift_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/shiftadd_dpath.sv
module shiftadd_dpath #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           load,
    input  logic           add,
    input  logic           shift,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic           lsb,
    output logic [2*W-1:0] acc
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc_q   = '0;
    logic [PW-1:0] mcand_q = '0;
    logic [W-1:0]  mplier_q = '0;

    always_ff @(posedge clk) begin
        if (load) begin
            acc_q    <= '0;
            mcand_q  <= {{W{1'b0}}, mcand_in};
            mplier_q <= mplier_in;
        end else if (add) begin
            acc_q <= acc_q + mcand_q;
        end else if (shift) begin
            mcand_q  <= {mcand_q[PW-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[W-1:1]};
        end
    end

    assign lsb = mplier_q[0];
    assign acc = acc_q;
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic           load_cmd,
    output logic           add_cmd,
    output logic           shift_cmd,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic mplier_lsb;
    logic last_iter;

    shiftadd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .lsb        (mplier_lsb),
        .last_shift (last_iter),
        .load_o     (load_cmd),
        .add_o      (add_cmd),
        .shift_o    (shift_cmd),
        .idle_o     (done)
    );

    shiftadd_iter_cnt #(.W(W)) u_cnt (
        .clk  (clk),
        .clr  (load_cmd),
        .inc  (shift_cmd),
        .last (last_iter)
    );

    shiftadd_dpath #(.W(W)) u_dp (
        .clk       (clk),
        .load      (load_cmd),
        .add       (add_cmd),
        .shift     (shift_cmd),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .lsb       (mplier_lsb),
        .acc       (product)
    );
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic lsb,
    input logic load_cmd,
    input logic add_cmd,
    input logic shift_cmd,
    input logic done
);
    logic in_test;
    assign in_test = !load_cmd && !add_cmd && !shift_cmd && !done;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (done && !load_cmd && !add_cmd && !shift_cmd));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> load_cmd);

    p_load_to_test_r3: assert property (@(posedge clk) disable iff (rst)
        load_cmd |=> in_test);

    p_branch_add_r4: assert property (@(posedge clk) disable iff (rst)
        (in_test && lsb) |=> add_cmd);

    p_branch_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (in_test && !lsb) |=> shift_cmd);

    p_add_then_shift_r4: assert property (@(posedge clk) disable iff (rst)
        add_cmd |=> shift_cmd);

    p_shift_exit_r5: assert property (@(posedge clk) disable iff (rst)
        shift_cmd |=> (done || in_test));

    p_strobes_excl_r6: assert property (@(posedge clk)
        $onehot0({load_cmd, add_cmd, shift_cmd, done}));
endmodule

bind shiftadd_mul shiftadd_mul_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .lsb       (mplier_lsb),
    .load_cmd  (load_cmd),
    .add_cmd   (add_cmd),
    .shift_cmd (shift_cmd),
    .done      (done)
);

// File: tb/tb_shiftadd_mul.sv
module tb_shiftadd_mul;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           load_cmd, add_cmd, shift_cmd, done;
    logic [2*W-1:0] product;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    shiftadd_mul #(.W(W)) dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplier),
        .load_cmd     (load_cmd),
        .add_cmd      (add_cmd),
        .shift_cmd    (shift_cmd),
        .done         (done),
        .product      (product)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {load_cmd, add_cmd, shift_cmd, done};
    endfunction

    task automatic t_powerup();
        @(negedge clk);
        @(negedge clk);
        check("R8 idle without reset", strobes(), 4'b0001);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset state", strobes(), 4'b0001);
        rst = 1'b0;
    endtask

    task automatic t_idle_hold();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2 idle hold", strobes(), 4'b0001);
        end
    endtask

    // poke >= 0 raises start for one cycle at that busy-cycle index
    task automatic t_mul(input logic [W-1:0] a, input logic [W-1:0] b, input int poke);
        int busy, loads, adds, shifts, multi;
        busy = 0; loads = 0; adds = 0; shifts = 0; multi = 0;
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3 load after start", load_cmd, 1);
        while (!done && busy < 100) begin
            if ($countones(strobes()) > 1) multi++;
            loads  += int'(load_cmd);
            adds   += int'(add_cmd);
            shifts += int'(shift_cmd);
            start = (busy == poke);
            busy++;
            @(negedge clk);
            start = 1'b0;
        end
        check("R3 single load", loads, 1);
        check("R4 add count", adds, $countones(b));
        check("R5 shift count", shifts, W);
        check("R5 busy cycles", busy, 1 + 2 * W + $countones(b));
        check("R6 exclusive strobes", multi, 0);
        check("R7 product", product, longint'(a) * longint'(b));
        if (poke >= 0) begin
            @(negedge clk);
            check("R9 idle after ignored start", strobes(), 4'b0001);
        end
    endtask

    task automatic t_reset_midrun();
        mcand  = 8'hC3;
        mplier = 8'h5A;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 busy before reset", done, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 idle after reset", strobes(), 4'b0001);
        @(negedge clk);
        check("R10 stays idle", strobes(), 4'b0001);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_powerup();
        t_reset();
        t_idle_hold();
        t_mul(8'd0,   8'd0,   -1);
        t_mul(8'd255, 8'd255, -1);
        t_mul(8'd1,   8'd255, -1);
        t_mul(8'd255, 8'd0,   -1);
        t_mul(8'hAA,  8'h55,  -1);
        t_mul(8'h55,  8'hAA,  -1);
        t_mul(8'd13,  8'd128, -1);
        for (int i = 0; i < 20; i++) begin
            t_mul(W'($urandom), W'($urandom), -1);
        end
        t_mul(8'd200, 8'hB7, 3);
        t_mul(8'd77,  8'h01, 15);
        t_reset_midrun();
        t_mul(8'd19,  8'd23, -1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule